// File: doc/BRIEF.md
# Lookup-Table Modular Reduction Unit

This block folds a double-width square back into a single-width polynomial without any division or trial subtraction. The 2N-bit input is cut into three fields. Each set bit of the low field and of the high field picks one N-bit constant from a table that is fixed at elaboration from an odd modulus M. The middle field is added in unchanged. All picked constants and the middle field are summed column by column in carry-save compressor trees. A final carry-propagate stage then adds each column's sum and carry. It keeps CW bits per coefficient and pushes the bits above that into the next coefficient up.

The low field is removed in the Montgomery manner. The result is therefore congruent to the input times R^-1 modulo M, where R = 2^(N/2), and not to the input itself. The output is only partly reduced: it is a polynomial in base 2^CW with slightly wide coefficients, so its value may exceed M. It is meant to feed the next squaring step of a repeated-squaring datapath. One input is accepted per clock, and the result is registered.

Top module: `mred_reduce`

## Requirements
- R1: For every accepted input X, the output value Y satisfies (Y · 2^(N/2)) mod M = X mod M, where N = CW·NC is the operand width.
- R2: The input fields are: low field din[N/2-1:0], middle field din[N/2+N-1:N/2], high field din[2N-1:N/2+N]. The output holds NC+1 coefficients of OW = CW+1 bits each, with coefficient k at res_o[k·OW +: OW], and its value is Y = Σ coef_k · 2^(CW·k).
- R3: When both the low and high fields are zero, the output equals the middle field exactly: coefficient k (k < NC) is its k-th CW-bit slice, and coefficient NC is zero.
- R4: An all-zero input produces an all-zero output.
- R5: Coefficient 0 is below 2^CW. Coefficients 1 to NC-1 are at most (2^CW-1)+(2^(SW-CW)-1). Coefficient NC is below 2^(SW-CW). Here SW = CW + ceil(log2(N+1)).
- R6: out_vld is high exactly in the cycle after in_vld was sampled high. The matching result appears on res_o on that same clock edge.
- R7: While in_vld is low, res_o keeps its previous value.
- R8: Synchronous reset clears out_vld and res_o to zero.
- R9: Inputs may arrive on back-to-back cycles. Each one yields its own correct result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input square is valid this cycle |
| din | input | 2·CW·NC | Double-width square to reduce |
| out_vld | output | 1 | Result register holds a new result |
| res_o | output | (NC+1)·(CW+1) | Partly reduced polynomial, coefficient k at [k·OW +: OW] |

## Verification
Every result is due exactly one clock edge after its input is sampled. The bench drives inputs on the falling edge. On the next falling edge it compares out_vld and res_o against a reference that holds the previous cycle's input. That reference checks congruence with a wide-integer modular product and never inspects the raw bit pattern, except in the zero and middle-only cases, where the exact pattern is known. The bench also idles for a few cycles between bursts, so it can confirm that the result register holds during gaps.

// File: rtl/mred_pkg.sv
package mred_pkg;

  localparam int MAXW = 1024;

  // 2^e mod m, by repeated doubling
  function automatic logic [MAXW-1:0] pow2_mod(input int e, input logic [MAXW-1:0] m);
    logic [MAXW-1:0] r;
    r = 1;
    for (int i = 0; i < e; i++) begin
      r = r << 1;
      if (r >= m) r = r - m;
    end
    return r;
  endfunction

  // 2^-k mod m for odd m, by repeated halving
  function automatic logic [MAXW-1:0] half_pow_mod(input int k, input logic [MAXW-1:0] m);
    logic [MAXW-1:0] r;
    r = 1;
    for (int i = 0; i < k; i++) begin
      if (r[0]) r = (r + m) >> 1;
      else      r = r >> 1;
    end
    return r;
  endfunction

  // number of 3:2 levels to bring n operands down to two
  function automatic int csa_levels(input int n);
    int c, l;
    c = n;
    l = 0;
    while (c > 2) begin
      c = c - c / 3;
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/mred_select.sv
module mred_select #(
  parameter int CW = 16,
  parameter int NC = 4,
  parameter logic [CW*NC-1:0] MOD = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*CW*NC-1:0]    din,
  output logic [(CW*NC+1)*CW*NC-1:0] terms_o
);
  localparam int N   = CW * NC;
  localparam int HB  = N / 2;
  localparam int HT  = N - HB;
  localparam int NTM = N + 1;
  localparam logic [mred_pkg::MAXW-1:0] MODX = mred_pkg::MAXW'(MOD);

  logic [HB-1:0] lo_bits;
  logic [N-1:0]  mid_bits;
  logic [HT-1:0] hi_bits;

  assign lo_bits  = din[HB-1:0];
  assign mid_bits = din[HB+N-1:HB];
  assign hi_bits  = din[2*N-1:HB+N];

  // low field: bit j weighs 2^j * R^-1
  for (genvar j = 0; j < HB; j++) begin : g_lo
    localparam logic [mred_pkg::MAXW-1:0] KF = mred_pkg::half_pow_mod(HB - j, MODX);
    assign terms_o[j*N +: N] = lo_bits[j] ? KF[N-1:0] : '0;
  end

  // high field: bit i sits at HB+N+i, times R^-1 gives 2^(N+i)
  for (genvar i = 0; i < HT; i++) begin : g_hi
    localparam logic [mred_pkg::MAXW-1:0] KF = mred_pkg::pow2_mod(N + i, MODX);
    assign terms_o[(HB+i)*N +: N] = hi_bits[i] ? KF[N-1:0] : '0;

    AST_TERM_LT_MOD: assert property (@(posedge clk) disable iff (rst)
      hi_bits[i] |-> (terms_o[(HB+i)*N +: N] < MOD)); // R1
  end

  assign terms_o[(NTM-1)*N +: N] = mid_bits;

endmodule

// File: rtl/mred_csa_tree.sv
module mred_csa_tree #(
  parameter int NOP = 65,
  parameter int W   = 23
) (
  input  logic [NOP*W-1:0] ops_i,
  output logic [W-1:0]     sum_o,
  output logic [W-1:0]     carry_o
);
  localparam int LVL = mred_pkg::csa_levels(NOP);
  localparam int NG  = NOP / 3;

  always_comb begin
    logic [W-1:0] v  [NOP];
    logic [W-1:0] nv [NOP];
    int cnt;
    int ng;
    for (int i = 0; i < NOP; i++) v[i] = ops_i[i*W +: W];
    cnt = NOP;
    for (int l = 0; l < LVL; l++) begin
      ng = cnt / 3;
      for (int i = 0; i < NOP; i++) nv[i] = '0;
      for (int g = 0; g < NG; g++) begin
        if (g < ng) begin
          nv[2*g]   = v[3*g] ^ v[3*g+1] ^ v[3*g+2];
          nv[2*g+1] = ((v[3*g] & v[3*g+1]) | (v[3*g] & v[3*g+2]) |
                       (v[3*g+1] & v[3*g+2])) << 1;
        end
      end
      for (int r = 0; r < NOP; r++) begin
        if (r >= 3*ng && r < cnt) nv[r-ng] = v[r];
      end
      for (int i = 0; i < NOP; i++) v[i] = nv[i];
      cnt = cnt - ng;
    end
    sum_o   = v[0];
    carry_o = v[1];
  end

endmodule

// File: rtl/mred_norm.sv
module mred_norm #(
  parameter int CW = 16,
  parameter int NC = 4,
  parameter int SW = 23,
  parameter int OW = 17
) (
  input  logic [NC*SW-1:0]     sum_i,
  input  logic [NC*SW-1:0]     carry_i,
  output logic [(NC+1)*OW-1:0] coef_o
);
  localparam int HW = SW - CW;

  logic [SW-1:0] col [NC];

  for (genvar k = 0; k < NC; k++) begin : g_col
    assign col[k] = sum_i[k*SW +: SW] + carry_i[k*SW +: SW];
    if (k == 0) begin : g_first
      assign coef_o[0 +: OW] = OW'(col[0][CW-1:0]);
    end else begin : g_rest
      assign coef_o[k*OW +: OW] = OW'(col[k][CW-1:0]) + OW'(col[k-1][SW-1:CW]);
    end
  end

  assign coef_o[NC*OW +: OW] = OW'(col[NC-1][SW-1:CW]);

  if (HW > OW) begin : g_bad
    initial $error("mred_norm: column headroom exceeds output coefficient width");
  end

endmodule

// File: rtl/mred_reduce.sv
module mred_reduce #(
  parameter int CW = 16,
  parameter int NC = 4,
  parameter logic [CW*NC-1:0] MOD = 64'hE3A1_5C97_0B2D_4F61
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_vld,
  input  logic [2*CW*NC-1:0]         din,
  output logic                       out_vld,
  output logic [(NC+1)*(CW+1)-1:0]   res_o
);
  localparam int N   = CW * NC;
  localparam int HB  = N / 2;
  localparam int NTM = N + 1;
  localparam int SW  = CW + $clog2(NTM);
  localparam int OW  = CW + 1;

  logic [NTM*N-1:0]       terms;
  logic [NC*SW-1:0]       csum;
  logic [NC*SW-1:0]       ccar;
  logic [(NC+1)*OW-1:0]   coef;
  logic [(NC+1)*OW-1:0]   res_q;
  logic                   vld_q;

  mred_select #(.CW(CW), .NC(NC), .MOD(MOD)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .terms_o (terms)
  );

  for (genvar k = 0; k < NC; k++) begin : g_tree
    logic [NTM*SW-1:0] ops;
    for (genvar t = 0; t < NTM; t++) begin : g_op
      assign ops[t*SW +: SW] = SW'(terms[t*N + k*CW +: CW]);
    end
    mred_csa_tree #(.NOP(NTM), .W(SW)) u_tree (
      .ops_i   (ops),
      .sum_o   (csum[k*SW +: SW]),
      .carry_o (ccar[k*SW +: SW])
    );
  end

  mred_norm #(.CW(CW), .NC(NC), .SW(SW), .OW(OW)) u_norm (
    .sum_i   (csum),
    .carry_i (ccar),
    .coef_o  (coef)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) res_q <= coef;
    end
  end

  assign out_vld = vld_q;
  assign res_o   = res_q;

  // expected pattern when only the middle field is populated
  logic [(NC+1)*OW-1:0] pass_exp;
  for (genvar k = 0; k < NC; k++) begin : g_pexp
    assign pass_exp[k*OW +: OW] = {1'b0, din[HB + k*CW +: CW]};
  end
  assign pass_exp[NC*OW +: OW] = '0;

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld); // R6
  AST_VLD_FALL: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(res_o)); // R7
  AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
    (in_vld && din == '0) |=> (res_o == '0)); // R4
  AST_PASS_MID: assert property (@(posedge clk) disable iff (rst)
    (in_vld && din[HB-1:0] == '0 && din[2*N-1:HB+N] == '0) |=> (res_o == $past(pass_exp))); // R3
  AST_COEF0_NARROW: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (res_o[CW] == 1'b0)); // R5

endmodule

// File: tb/mred_reduce_tb.sv
module mred_reduce_tb;
  localparam int CW = 16;
  localparam int NC = 4;
  localparam int N  = CW * NC;
  localparam int HB = N / 2;
  localparam int OW = CW + 1;
  localparam int SW = CW + $clog2(N + 1);
  localparam logic [N-1:0] MOD = 64'hE3A1_5C97_0B2D_4F61;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [2*N-1:0] din = '0;
  logic out_vld;
  logic [(NC+1)*OW-1:0] res_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference state: what was driven in the previous cycle
  bit             prev_vld = 0;
  logic [2*N-1:0] prev_x   = '0;
  logic [(NC+1)*OW-1:0] last_res = '0;

  always #2 clk = ~clk;

  mred_reduce #(.CW(CW), .NC(NC), .MOD(MOD)) u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .din(din),
    .out_vld(out_vld), .res_o(res_o)
  );

  function automatic logic [255:0] poly_value(input logic [(NC+1)*OW-1:0] r);
    logic [255:0] y;
    y = '0;
    for (int k = 0; k <= NC; k++) y = y + (256'(r[k*OW +: OW]) << (CW*k));
    return y;
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // compare outputs against the input of the previous cycle
  task automatic compare_cycle();
    logic [255:0] y, lhs, rhs;
    logic [(NC+1)*OW-1:0] pexp;
    check(out_vld == prev_vld, "R6", $sformatf("%0b", out_vld), $sformatf("%0b", prev_vld));
    if (prev_vld) begin
      y   = poly_value(res_o);
      lhs = (y << HB) % 256'(MOD);
      rhs = 256'(prev_x) % 256'(MOD);
      check(lhs == rhs, "R1/R9 congruence", $sformatf("%h", lhs), $sformatf("%h", rhs));
      check(res_o[CW] == 1'b0, "R5 coef0", $sformatf("%h", res_o[0 +: OW]), "< 2^CW");
      for (int k = 1; k < NC; k++)
        check(res_o[k*OW +: OW] <= OW'((2**CW - 1) + (2**(SW-CW) - 1)), "R5 middle coef",
              $sformatf("%h", res_o[k*OW +: OW]), "within bound");
      check(res_o[NC*OW +: OW] < OW'(2**(SW-CW)), "R5 top coef",
            $sformatf("%h", res_o[NC*OW +: OW]), "< 2^(SW-CW)");
      if (prev_x == '0)
        check(res_o == '0, "R4 zero", $sformatf("%h", res_o), "0");
      if (prev_x[HB-1:0] == '0 && prev_x[2*N-1:HB+N] == '0) begin
        pexp = '0;
        for (int k = 0; k < NC; k++) pexp[k*OW +: OW] = {1'b0, prev_x[HB + k*CW +: CW]};
        check(res_o == pexp, "R3 middle pass", $sformatf("%h", res_o), $sformatf("%h", pexp));
      end
      last_res = res_o;
    end else begin
      check(res_o == last_res, "R7 hold", $sformatf("%h", res_o), $sformatf("%h", last_res));
    end
  endtask

  task automatic step(input bit v, input logic [2*N-1:0] x);
    @(negedge clk);
    compare_cycle();
    in_vld   = v;
    din      = x;
    prev_vld = v;
    prev_x   = x;
  endtask

  function automatic logic [2*N-1:0] rnd_word();
    logic [2*N-1:0] w;
    for (int i = 0; i < 2*N/32; i++) w[i*32 +: 32] = $urandom();
    return w;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0 && res_o == '0, "R8 reset", $sformatf("%b/%h", out_vld, res_o), "0/0");
    @(negedge clk);
    rst = 1'b0;
    // R4 zero input
    step(1, '0);
    // R3 middle-only inputs (R2 field positions)
    step(1, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0} >> 0);
    step(1, {32'h0, 64'h1234_5678_9ABC_DEF0, 32'h0});
    // single high and low bits
    step(1, 128'h1 << (HB + N));
    step(1, 128'h1 << (2*N - 1));
    step(1, 128'h1);
    step(1, 128'h1 << (HB - 1));
    // all ones
    step(1, '1);
    // idle gap: R7
    step(0, rnd_word());
    step(0, rnd_word());
    step(0, '1);
    // R9 back-to-back random
    for (int i = 0; i < 300; i++) step(1, rnd_word());
    // random with idle gaps
    for (int i = 0; i < 300; i++) step(($urandom() % 3) != 0, rnd_word());
    step(0, '0);
    step(0, '0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule